// File: doc/BRIEF.md
# Execution Trace and Completion Monitor

This block sits next to a processor core and observes three of its interfaces: the instruction-fetch bus, the register-file write port and the data bus. From these it produces three streams of single-cycle trace events. Instruction fetches inside a configured code window give one stream. Register writes to any register except register zero give a second. Acknowledged data stores give the third, and each store event carries the full word as it reads after the byte-enable merge. A verification environment or an on-chip trace sink consumes the events, one cycle after the transfer that caused them.

The monitor also decides when a run has ended. A store whose merged word equals 1 at the designated completion address raises a done flag. A run that reaches no completion within a configurable cycle budget raises a timeout flag instead. Either flag holds until reset and silences all event streams. The code window bounds, the completion address and the cycle budget are elaboration parameters.

Top module: `exec_trace_mon`

## Requirements
- R1: A fetch event (`fetch_vld` high for one cycle, on the clock edge after the transfer) is produced for a cycle with `ib_req` and `ib_ack` high whose `ib_addr` satisfies CODE_LO <= addr < CODE_HI. An acknowledged fetch below CODE_LO or at/above CODE_HI produces no event.
- R2: A fetch event carries the transfer's byte address on `fetch_addr` and the returned instruction word on `fetch_insn`.
- R3: A register event is produced on the edge after a cycle with `rf_we` high and `rf_idx` nonzero, and it carries the index and the written data. A write with `rf_idx` equal to 0 produces no event.
- R4: Every cycle with `db_req`, `db_ack` and `db_we` high produces a store event carrying `db_addr` and the merged word. In that word, byte i (bits 8i+7..8i) comes from `db_wdata` when `db_sel[i]` is 1 and from `db_rdata` (the word's prior contents) otherwise. Reads and unacknowledged writes produce no event.
- R5: `done` rises on the edge after an acknowledged store whose address matches DONE_ADDR in bits 31..2 and whose merged word equals 1. A store of any other value to that address leaves `done` low.
- R6: When `done` is still low, `timeout` rises at the TIMEOUT_CYCLES-th rising edge after reset is released, and not before.
- R7: Once `done` or `timeout` is high, it stays high until reset. From the edge after it rises, no fetch, register or store event is produced.
- R8: While `rst` is high, all event strobes, `done` and `timeout` are low, whatever the bus inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ib_req | input | 1 | Instruction bus request |
| ib_ack | input | 1 | Instruction bus acknowledge |
| ib_addr | input | 32 | Instruction byte address |
| ib_rdata | input | 32 | Instruction word returned |
| rf_we | input | 1 | Register-file write enable |
| rf_idx | input | 5 | Register-file write index |
| rf_wdata | input | 32 | Register-file write data |
| db_req | input | 1 | Data bus request |
| db_ack | input | 1 | Data bus acknowledge |
| db_we | input | 1 | Data bus write (1) or read (0) |
| db_sel | input | 4 | Byte enables, bit i selects byte i |
| db_addr | input | 32 | Data byte address |
| db_wdata | input | 32 | Store data |
| db_rdata | input | 32 | Current word contents at the address |
| fetch_vld | output | 1 | Fetch event strobe |
| fetch_addr | output | 32 | Fetch event address |
| fetch_insn | output | 32 | Fetch event instruction word |
| commit_vld | output | 1 | Register event strobe |
| commit_idx | output | 5 | Register event index |
| commit_data | output | 32 | Register event data |
| store_vld | output | 1 | Store event strobe |
| store_addr | output | 32 | Store event address |
| store_word | output | 32 | Store event merged word |
| done | output | 1 | Completion flag |
| timeout | output | 1 | Cycle-budget expiry flag |

## Verification
Four properties are checked on every clock. A fetch outside the code window or a write to register zero is never followed by an event. Reads on the data bus never yield a store event. Both end flags are sticky and silence every event stream, and the cycle counter never passes its budget while the timeout flag is low. Only the directed scenarios can show the payload values, the byte-merge arithmetic for particular enable patterns, the exact window boundaries, the value test on the completion word and the exact cycle on which the timeout rises.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int NBYTES    = XLEN / 8;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] word;
    } addr_word_ev_t;

    typedef struct packed {
        logic                 vld;
        logic [REG_IDX_W-1:0] idx;
        logic [XLEN-1:0]      data;
    } commit_ev_t;

    // Byte-enable merge of new data over the prior word contents.
    function automatic logic [XLEN-1:0] merge_bytes(
        input logic [XLEN-1:0]   old_word,
        input logic [XLEN-1:0]   new_word,
        input logic [NBYTES-1:0] sel
    );
        logic [XLEN-1:0] res;
        for (int b = 0; b < NBYTES; b++) begin
            res[8*b +: 8] = sel[b] ? new_word[8*b +: 8] : old_word[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/fetch_filter.sv
module fetch_filter
    import trace_pkg::*;
#(
    parameter logic [XLEN-1:0] CODE_LO = 32'h0000_0000,
    parameter logic [XLEN-1:0] CODE_HI = 32'h0001_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            halt,
    input  logic            req,
    input  logic            ack,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] rdata,
    output addr_word_ev_t   ev
);

    logic in_window;
    assign in_window = (addr >= CODE_LO) && (addr < CODE_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            ev <= '0;
        end else begin
            ev.vld  <= req && ack && in_window && !halt;
            ev.addr <= addr;
            ev.word <= rdata;
        end
    end

    // R1: an acknowledged fetch outside the window never yields an event
    assert_fetch_window_R1: assert property (@(posedge clk) disable iff (rst)
        (req && ack && ((addr < CODE_LO) || (addr >= CODE_HI))) |=> !ev.vld);

endmodule

// File: rtl/commit_filter.sv
module commit_filter
    import trace_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 halt,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [XLEN-1:0]      wdata,
    output commit_ev_t           ev
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ev <= '0;
        end else begin
            ev.vld  <= we && (idx != '0) && !halt;
            ev.idx  <= idx;
            ev.data <= wdata;
        end
    end

    // R3: writes to register zero are never reported
    assert_no_zero_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (we && idx == '0) |=> !ev.vld);

endmodule

// File: rtl/store_tracker.sv
module store_tracker
    import trace_pkg::*;
#(
    parameter logic [XLEN-1:0] DONE_ADDR = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic              req,
    input  logic              ack,
    input  logic              we,
    input  logic [NBYTES-1:0] sel,
    input  logic [XLEN-1:0]   addr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [XLEN-1:0]   rdata,
    output addr_word_ev_t     ev,
    output logic              done
);

    logic            wr_xfer;
    logic            hits_done;
    logic [XLEN-1:0] merged;

    assign wr_xfer   = req && ack && we && !halt;
    assign merged    = merge_bytes(rdata, wdata, sel);
    assign hits_done = (addr[XLEN-1:2] == DONE_ADDR[XLEN-1:2]) && (merged == XLEN'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ev   <= '0;
            done <= 1'b0;
        end else begin
            ev.vld  <= wr_xfer;
            ev.addr <= addr;
            ev.word <= merged;
            if (wr_xfer && hits_done) begin
                done <= 1'b1;
            end
        end
    end

    // R4: reads on the data bus never produce a store event
    assert_read_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (req && ack && !we) |=> !ev.vld);

endmodule

// File: rtl/run_timer.sv
module run_timer #(
    parameter int LIMIT = 60000
) (
    input  logic clk,
    input  logic rst,
    input  logic done,
    output logic timeout
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else if (!done && !timeout) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(LIMIT - 1)) begin
                timeout <= 1'b1;
            end
        end
    end

    // R6: the counter never reaches the budget while timeout is low
    assert_budget_bound_R6: assert property (@(posedge clk) disable iff (rst)
        !timeout |-> (cnt < CW'(LIMIT)));

    // R7: timeout is sticky
    assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        timeout |=> timeout);

endmodule

// File: rtl/exec_trace_mon.sv
module exec_trace_mon
    import trace_pkg::*;
#(
    parameter logic [XLEN-1:0] CODE_LO        = 32'h0000_0000,
    parameter logic [XLEN-1:0] CODE_HI        = 32'h0001_0000,
    parameter logic [XLEN-1:0] DONE_ADDR      = 32'h0000_1000,
    parameter int              TIMEOUT_CYCLES = 60000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ib_req,
    input  logic                 ib_ack,
    input  logic [XLEN-1:0]      ib_addr,
    input  logic [XLEN-1:0]      ib_rdata,
    input  logic                 rf_we,
    input  logic [REG_IDX_W-1:0] rf_idx,
    input  logic [XLEN-1:0]      rf_wdata,
    input  logic                 db_req,
    input  logic                 db_ack,
    input  logic                 db_we,
    input  logic [NBYTES-1:0]    db_sel,
    input  logic [XLEN-1:0]      db_addr,
    input  logic [XLEN-1:0]      db_wdata,
    input  logic [XLEN-1:0]      db_rdata,
    output logic                 fetch_vld,
    output logic [XLEN-1:0]      fetch_addr,
    output logic [XLEN-1:0]      fetch_insn,
    output logic                 commit_vld,
    output logic [REG_IDX_W-1:0] commit_idx,
    output logic [XLEN-1:0]      commit_data,
    output logic                 store_vld,
    output logic [XLEN-1:0]      store_addr,
    output logic [XLEN-1:0]      store_word,
    output logic                 done,
    output logic                 timeout
);

    addr_word_ev_t fetch_ev;
    addr_word_ev_t store_ev;
    commit_ev_t    commit_ev;
    logic          halt;

    assign halt = done || timeout;

    fetch_filter #(
        .CODE_LO (CODE_LO),
        .CODE_HI (CODE_HI)
    ) u_fetch (
        .clk   (clk),
        .rst   (rst),
        .halt  (halt),
        .req   (ib_req),
        .ack   (ib_ack),
        .addr  (ib_addr),
        .rdata (ib_rdata),
        .ev    (fetch_ev)
    );

    commit_filter u_commit (
        .clk   (clk),
        .rst   (rst),
        .halt  (halt),
        .we    (rf_we),
        .idx   (rf_idx),
        .wdata (rf_wdata),
        .ev    (commit_ev)
    );

    store_tracker #(
        .DONE_ADDR (DONE_ADDR)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .halt  (halt),
        .req   (db_req),
        .ack   (db_ack),
        .we    (db_we),
        .sel   (db_sel),
        .addr  (db_addr),
        .wdata (db_wdata),
        .rdata (db_rdata),
        .ev    (store_ev),
        .done  (done)
    );

    run_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .timeout (timeout)
    );

    assign fetch_vld   = fetch_ev.vld;
    assign fetch_addr  = fetch_ev.addr;
    assign fetch_insn  = fetch_ev.word;
    assign commit_vld  = commit_ev.vld;
    assign commit_idx  = commit_ev.idx;
    assign commit_data = commit_ev.data;
    assign store_vld   = store_ev.vld;
    assign store_addr  = store_ev.addr;
    assign store_word  = store_ev.word;

    // R7: done is sticky
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R7: after an end flag, every event stream stays quiet
    assert_quiet_after_end_R7: assert property (@(posedge clk) disable iff (rst)
        halt |=> (!fetch_vld && !commit_vld && !store_vld));

endmodule

// File: tb/exec_trace_mon_bench.sv
module exec_trace_mon_bench;

    localparam logic [31:0] LO   = 32'h0000_0100;
    localparam logic [31:0] HI   = 32'h0000_0200;
    localparam logic [31:0] TOH  = 32'h0000_1000;
    localparam int          TMO  = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ib_req = 0, ib_ack = 0;
    logic [31:0] ib_addr = '0, ib_rdata = '0;
    logic        rf_we = 0;
    logic [4:0]  rf_idx = '0;
    logic [31:0] rf_wdata = '0;
    logic        db_req = 0, db_ack = 0, db_we = 0;
    logic [3:0]  db_sel = '0;
    logic [31:0] db_addr = '0, db_wdata = '0, db_rdata = '0;
    logic        fetch_vld, commit_vld, store_vld, done, timeout;
    logic [31:0] fetch_addr, fetch_insn, commit_data, store_addr, store_word;
    logic [4:0]  commit_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    exec_trace_mon #(
        .CODE_LO        (LO),
        .CODE_HI        (HI),
        .DONE_ADDR      (TOH),
        .TIMEOUT_CYCLES (TMO)
    ) u_exec_trace_mon (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ib_req = 0; ib_ack = 0; rf_we = 0; db_req = 0; db_ack = 0; db_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic fetch_once(input logic [31:0] a, input logic [31:0] w, input bit expect_ev);
        @(negedge clk);
        ib_req = 1; ib_ack = 1; ib_addr = a; ib_rdata = w;
        @(negedge clk);
        ib_req = 0; ib_ack = 0;
        chk(fetch_vld == expect_ev, "R1", "fetch strobe", 32'(fetch_vld), 32'(expect_ev));
        if (expect_ev) begin
            chk(fetch_addr == a, "R2", "fetch address", fetch_addr, a);
            chk(fetch_insn == w, "R2", "fetch word", fetch_insn, w);
        end
    endtask

    task automatic commit_once(input logic [4:0] i, input logic [31:0] d, input bit expect_ev);
        @(negedge clk);
        rf_we = 1; rf_idx = i; rf_wdata = d;
        @(negedge clk);
        rf_we = 0;
        chk(commit_vld == expect_ev, "R3", "commit strobe", 32'(commit_vld), 32'(expect_ev));
        if (expect_ev) begin
            chk(commit_idx == i, "R3", "commit index", 32'(commit_idx), 32'(i));
            chk(commit_data == d, "R3", "commit data", commit_data, d);
        end
    endtask

    task automatic store_once(input bit we, input bit ack, input logic [3:0] s,
                              input logic [31:0] a, input logic [31:0] wd,
                              input logic [31:0] old, input bit expect_ev,
                              input logic [31:0] exp_word);
        @(negedge clk);
        db_req = 1; db_ack = ack; db_we = we; db_sel = s;
        db_addr = a; db_wdata = wd; db_rdata = old;
        @(negedge clk);
        db_req = 0; db_ack = 0; db_we = 0;
        chk(store_vld == expect_ev, "R4", "store strobe", 32'(store_vld), 32'(expect_ev));
        if (expect_ev) begin
            chk(store_addr == a, "R4", "store address", store_addr, a);
            chk(store_word == exp_word, "R4", "merged word", store_word, exp_word);
        end
    endtask

    task automatic t_reset_r8();
        @(negedge clk);
        rst = 1;
        ib_req = 1; ib_ack = 1; ib_addr = LO; rf_we = 1; rf_idx = 5'd3;
        db_req = 1; db_ack = 1; db_we = 1; db_sel = 4'hF; db_addr = TOH; db_wdata = 32'd1;
        @(negedge clk);
        @(negedge clk);
        chk(!fetch_vld && !commit_vld && !store_vld, "R8", "strobes in reset",
            {29'd0, fetch_vld, commit_vld, store_vld}, 32'd0);
        chk(!done && !timeout, "R8", "flags in reset", {30'd0, done, timeout}, 32'd0);
        idle_inputs();
    endtask

    task automatic t_fetch_r1();
        do_reset();
        fetch_once(LO, 32'h0000_0013, 1'b1);
        fetch_once(LO - 32'd4, 32'h1111_1111, 1'b0);
        fetch_once(HI - 32'd4, 32'hDEAD_BEEF, 1'b1);
        fetch_once(HI, 32'h2222_2222, 1'b0);
        fetch_once(32'h0000_0180, 32'h00A0_0093, 1'b1);
        @(negedge clk);
        ib_req = 1; ib_ack = 0; ib_addr = 32'h0000_0104;
        @(negedge clk);
        ib_req = 0;
        chk(!fetch_vld, "R1", "unacked fetch", 32'(fetch_vld), 32'd0);
    endtask

    task automatic t_commit_r3();
        do_reset();
        commit_once(5'd1, 32'h1234_5678, 1'b1);
        commit_once(5'd0, 32'hFFFF_FFFF, 1'b0);
        commit_once(5'd31, 32'h0BAD_F00D, 1'b1);
    endtask

    task automatic t_store_r4();
        do_reset();
        store_once(1, 1, 4'hF, 32'h0000_0400, 32'hAABB_CCDD, 32'h1122_3344, 1, 32'hAABB_CCDD);
        store_once(1, 1, 4'b0110, 32'h0000_0404, 32'hAABB_CCDD, 32'h1122_3344, 1, 32'h11BB_CC44);
        store_once(1, 1, 4'b1000, 32'h0000_0408, 32'h9900_0000, 32'h1122_3344, 1, 32'h9922_3344);
        store_once(0, 1, 4'hF, 32'h0000_040C, 32'h5555_5555, 32'h0, 0, 32'h0);
        store_once(1, 0, 4'hF, 32'h0000_0410, 32'h6666_6666, 32'h0, 0, 32'h0);
    endtask

    task automatic t_done_r5();
        do_reset();
        store_once(1, 1, 4'hF, TOH, 32'd2, 32'd0, 1, 32'd2);
        chk(!done, "R5", "done after value 2", 32'(done), 32'd0);
        store_once(1, 1, 4'hF, TOH + 32'd4, 32'd1, 32'd0, 1, 32'd1);
        chk(!done, "R5", "done after neighbour word", 32'(done), 32'd0);
        store_once(1, 1, 4'b0001, TOH, 32'h0000_0001, 32'h0000_0000, 1, 32'd1);
        chk(done, "R5", "done after value 1", 32'(done), 32'd1);
        fetch_once(LO, 32'h13, 1'b0);
        commit_once(5'd4, 32'h44, 1'b0);
        store_once(1, 1, 4'hF, 32'h0000_0400, 32'h1, 32'h0, 0, 32'h0);
        chk(done, "R7", "done sticky", 32'(done), 32'd1);
        repeat (TMO) @(negedge clk);
        chk(!timeout, "R7", "no timeout after done", 32'(timeout), 32'd0);
    endtask

    task automatic t_timeout_r6();
        do_reset();
        repeat (TMO - 1) @(negedge clk);
        chk(!timeout, "R6", "timeout one edge early", 32'(timeout), 32'd0);
        @(negedge clk);
        chk(timeout, "R6", "timeout at budget", 32'(timeout), 32'd1);
        fetch_once(LO, 32'h13, 1'b0);
        store_once(1, 1, 4'hF, TOH, 32'd1, 32'd0, 0, 32'h0);
        chk(!done && timeout, "R7", "flags after timeout", {30'd0, done, timeout}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_r8();
        t_fetch_r1();
        t_commit_r3();
        t_store_r4();
        t_done_r5();
        t_timeout_r6();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule